// File: doc/BRIEF.md
# Dual-Mode PWM Timebase with Direction-Qualified Compares

This block is the timebase of a PWM channel. It holds a counter that runs from a programmable period value in one of two modes. In count-down mode it steps from the period value down to zero and then reloads. In up/down mode it climbs from zero to the period value and falls back, which gives center-aligned waveforms. Next to the count and a direction flag it produces one-cycle event strobes: the counter at zero, the counter at the period value, and a match for each of two compare thresholds. In up/down mode each compare match goes to a rising-half output or a falling-half output, depending on the direction.

Waveform action logic, dead-band and fault stages sit downstream and only consume these strobes. The period and the two thresholds pass through shadow registers. Those registers capture new values only when the counter arrives at zero, so a running period is never cut short. All outputs are registered, and every strobe is valid in the same cycle as the `count` value it describes.

Top module: `pwm_timebase`

## Requirements
- R1: With `mode`=0 (count-down) and `en` high, `count` goes L-1, L-2, ... 0, L, L-1, ... after enable, where L is the period. `dir` stays 0 in this mode.
- R2: With `mode`=1 (up/down), period L>0 and `en` high, the first enabled cycle shows `count`=0. The count then rises by one per cycle to L and falls by one per cycle to 0, with period 2L. `dir` is 1 while the count is 0 or rising and 0 while the count is at L or falling.
- R3: `zero_evt` is high exactly in the cycles where `count`=0, and `load_evt` exactly in the cycles where `count` equals the active period. In count-down mode with L>0, every `zero_evt` cycle is followed at once by a `load_evt` cycle.
- R4: When `count` equals an active threshold, the compare unit raises its `_up` output if `dir`=1 and its `_dn` output if `dir`=0. In count-down mode every match therefore appears on `_dn`. Index A uses `cmpa_*` and index B uses `cmpb_*`.
- R5: A threshold greater than the active period never raises either of its outputs.
- R6: Changes to `load_val`, `cmpa_val` and `cmpb_val` while enabled take effect only from the cycle after `count` reaches 0.
- R7: While `en` is low, `count` holds the start value (`load_val` in count-down mode, 0 in up/down mode), `dir` is 0, and all event outputs are 0.
- R8: With period 0, `count` stays 0, `zero_evt` and `load_evt` are both high in every enabled cycle, and `dir` stays 0.
- R9: Synchronous active-high `rst` clears all event outputs and `dir`, and sets `count` to the start value of the selected mode. After release the sequence restarts as if just enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| mode | input | 1 | 0 = count-down, 1 = up/down |
| load_val | input | W | Period value |
| cmpa_val | input | W | Threshold A |
| cmpb_val | input | W | Threshold B |
| count | output | W | Current counter value |
| dir | output | 1 | 1 = rising half, 0 = falling half |
| zero_evt | output | 1 | Counter-at-zero strobe |
| load_evt | output | 1 | Counter-at-period strobe |
| cmpa_up | output | 1 | Threshold A hit while rising |
| cmpa_dn | output | 1 | Threshold A hit while falling |
| cmpb_up | output | 1 | Threshold B hit while rising |
| cmpb_dn | output | 1 | Threshold B hit while falling |

## Verification
The bench sweeps both modes over periods 0 to 6 and thresholds 0 to 7, so each threshold falls below, at and above the period. A threshold at 0 or at the period separates the single-visit turning points from values passed twice. A threshold above the period shows suppression, and the period of 0 exercises the degenerate case where both strobes stay high. A change to the period in the middle of a count-down period shows whether the shadow waits for zero. A reset during an up/down run shows a clean restart.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
    typedef enum logic {
        CNT_DOWN = 1'b0,
        CNT_UPDN = 1'b1
    } cnt_mode_e;
endpackage

// File: rtl/ptb_shadow.sv
`timescale 1ns/1ps
module ptb_shadow #(
    parameter int W    = 16,
    parameter int NCMP = 2
) (
    input  logic                       clk,
    input  logic                       capture,
    input  logic [W-1:0]               load_in,
    input  logic [NCMP-1:0][W-1:0]     cmp_in,
    output logic [W-1:0]               ld_q,
    output logic [W-1:0]               ld_d,
    output logic [NCMP-1:0][W-1:0]     cmp_d
);
    typedef struct packed {
        logic [W-1:0]           ld;
        logic [NCMP-1:0][W-1:0] cmp;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (capture) begin
            sh_d.ld  = load_in;
            sh_d.cmp = cmp_in;
        end
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign ld_q  = sh_q.ld;
    assign ld_d  = sh_d.ld;
    assign cmp_d = sh_d.cmp;
endmodule

// File: rtl/ptb_counter.sv
`timescale 1ns/1ps
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         run,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] ld_q,
    input  logic [W-1:0] load_in,
    output logic [W-1:0] cnt_q,
    output logic         dir_q,
    output logic [W-1:0] cnt_d,
    output logic         dir_d
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir;
    } ctr_t;

    ctr_t st_d, st_q;
    logic [W-1:0] ld_m1;

    assign ld_m1 = ld_q - ONE;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = (mode == CNT_UPDN) ? '0 : load_in;
            st_d.dir = 1'b0;
        end else if (mode == CNT_DOWN) begin
            st_d.dir = 1'b0;
            st_d.cnt = (st_q.cnt == '0) ? ld_q : st_q.cnt - ONE;
        end else if (ld_q == '0) begin
            st_d.cnt = '0;
            st_d.dir = 1'b0;
        end else if (st_q.dir) begin
            if (st_q.cnt >= ld_m1) begin
                st_d.cnt = ld_q;
                st_d.dir = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
                st_d.dir = 1'b1;
            end
        end else begin
            if (st_q.cnt <= ONE) begin
                st_d.cnt = '0;
                st_d.dir = (load_in != '0);
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                st_d.dir = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
    assign dir_q = st_q.dir;
    assign cnt_d = st_d.cnt;
    assign dir_d = st_d.dir;
endmodule

// File: rtl/ptb_events.sv
`timescale 1ns/1ps
module ptb_events #(
    parameter int W    = 16,
    parameter int NCMP = 2
) (
    input  logic                   clk,
    input  logic                   run,
    input  logic [W-1:0]           cnt_d,
    input  logic                   dir_d,
    input  logic [W-1:0]           ld_d,
    input  logic [NCMP-1:0][W-1:0] cmp_d,
    output logic                   zero_q,
    output logic                   load_q,
    output logic [NCMP-1:0]        up_q,
    output logic [NCMP-1:0]        dn_q
);
    typedef struct packed {
        logic            zero;
        logic            load;
        logic [NCMP-1:0] up;
        logic [NCMP-1:0] dn;
    } evt_t;

    evt_t ev_d, ev_q;
    logic [NCMP-1:0] hit;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign hit[i] = (cmp_d[i] <= ld_d) && (cnt_d == cmp_d[i]);
    end

    always_comb begin
        ev_d = '0;
        if (run) begin
            ev_d.zero = (cnt_d == '0);
            ev_d.load = (cnt_d == ld_d);
            ev_d.up   = hit & {NCMP{dir_d}};
            ev_d.dn   = hit & {NCMP{~dir_d}};
        end
    end

    always_ff @(posedge clk) begin
        ev_q <= ev_d;
    end

    assign zero_q = ev_q.zero;
    assign load_q = ev_q.load;
    assign up_q   = ev_q.up;
    assign dn_q   = ev_q.dn;
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         mode,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmpa_val,
    input  logic [W-1:0] cmpb_val,
    output logic [W-1:0] count,
    output logic         dir,
    output logic         zero_evt,
    output logic         load_evt,
    output logic         cmpa_up,
    output logic         cmpa_dn,
    output logic         cmpb_up,
    output logic         cmpb_dn
);
    localparam int NCMP = 2;

    logic                   run;
    logic                   capture;
    logic [W-1:0]           ld_q, ld_d, cnt_d;
    logic                   dir_d;
    logic [NCMP-1:0][W-1:0] cmp_bus, cmp_d;
    logic [NCMP-1:0]        up_q, dn_q;

    assign run     = en & ~rst;
    assign cmp_bus = {cmpb_val, cmpa_val};
    assign capture = ~run | (cnt_d == '0);

    ptb_shadow #(.W(W), .NCMP(NCMP)) u_shadow (
        .clk     (clk),
        .capture (capture),
        .load_in (load_val),
        .cmp_in  (cmp_bus),
        .ld_q    (ld_q),
        .ld_d    (ld_d),
        .cmp_d   (cmp_d)
    );

    ptb_counter #(.W(W)) u_counter (
        .clk     (clk),
        .run     (run),
        .mode    (cnt_mode_e'(mode)),
        .ld_q    (ld_q),
        .load_in (load_val),
        .cnt_q   (count),
        .dir_q   (dir),
        .cnt_d   (cnt_d),
        .dir_d   (dir_d)
    );

    ptb_events #(.W(W), .NCMP(NCMP)) u_events (
        .clk    (clk),
        .run    (run),
        .cnt_d  (cnt_d),
        .dir_d  (dir_d),
        .ld_d   (ld_d),
        .cmp_d  (cmp_d),
        .zero_q (zero_evt),
        .load_q (load_evt),
        .up_q   (up_q),
        .dn_q   (dn_q)
    );

    assign cmpa_up = up_q[0];
    assign cmpa_dn = dn_q[0];
    assign cmpb_up = up_q[1];
    assign cmpb_dn = dn_q[1];
endmodule

// File: rtl/ptb_checker.sv
`timescale 1ns/1ps
module ptb_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         mode,
    input logic [W-1:0] count,
    input logic         dir,
    input logic         zero_evt,
    input logic         load_evt,
    input logic         cmpa_up,
    input logic         cmpa_dn,
    input logic         cmpb_up,
    input logic         cmpb_dn
);
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !mode && count != '0) |=> (count == $past(count) - 1'b1)); // R1

    AST_DOWN_DIR_LOW: assert property (@(posedge clk) disable iff (rst)
        !mode |=> !dir); // R1

    AST_UPDN_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && mode) |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
                          || (count == $past(count) - 1'b1))); // R2

    AST_ZERO_THEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (zero_evt && !load_evt && !mode && en) |=> load_evt); // R3

    AST_UP_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst)
        (cmpa_up || cmpb_up) |-> dir); // R4

    AST_DN_NEEDS_NODIR: assert property (@(posedge clk) disable iff (rst)
        (cmpa_dn || cmpb_dn) |-> !dir); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(zero_evt || load_evt || cmpa_up || cmpa_dn || cmpb_up || cmpb_dn)); // R7
endmodule

bind pwm_timebase ptb_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mode     (mode),
    .count    (count),
    .dir      (dir),
    .zero_evt (zero_evt),
    .load_evt (load_evt),
    .cmpa_up  (cmpa_up),
    .cmpa_dn  (cmpa_dn),
    .cmpb_up  (cmpb_up),
    .cmpb_dn  (cmpb_dn)
);

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] cmpa_val = '0;
    logic [W-1:0] cmpb_val = '0;
    logic [W-1:0] count;
    logic         dir, zero_evt, load_evt, cmpa_up, cmpa_dn, cmpb_up, cmpb_dn;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_timebase #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .load_val(load_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
        .count(count), .dir(dir), .zero_evt(zero_evt), .load_evt(load_evt),
        .cmpa_up(cmpa_up), .cmpa_dn(cmpa_dn), .cmpb_up(cmpb_up), .cmpb_dn(cmpb_dn)
    );

    function automatic logic [W+6:0] observed();
        return {count, dir, zero_evt, load_evt, cmpa_up, cmpa_dn, cmpb_up, cmpb_dn};
    endfunction

    // Expected {count, dir, zero, load, a_up, a_dn, b_up, b_dn} in the k-th enabled cycle (k=0: idle)
    function automatic logic [W+6:0] expv(int m, int l, int ca, int cb, int k);
        int c, d, p;
        logic z, ld, ma, mb;
        if (k == 0) begin
            c = (m != 0) ? 0 : l;
            return {c[W-1:0], 7'b0};
        end
        if (l == 0) begin
            c = 0; d = 0;
        end else if (m == 0) begin
            c = l - (k % (l + 1)); d = 0;
        end else begin
            p = (k - 1) % (2 * l);
            c = (p <= l) ? p : 2 * l - p;
            d = (p < l) ? 1 : 0;
        end
        z  = (c == 0);
        ld = (c == l);
        ma = (ca <= l) && (c == ca);
        mb = (cb <= l) && (c == cb);
        return {c[W-1:0], d[0], z, ld, ma & d[0], ma & ~d[0], mb & d[0], mb & ~d[0]};
    endfunction

    task automatic check(string req, logic [W+6:0] exp);
        logic [W+6:0] act;
        act = observed();
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state with mode=0, load 9
        load_val = 16'd9;
        cmpa_val = 16'd3;
        cmpb_val = 16'd4;
        repeat (3) step();
        check("R9", expv(0, 9, 3, 4, 0));
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R7 R8: sweep of mode, period and thresholds
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l <= 6; l++) begin
                for (int ca = 0; ca < 8; ca++) begin
                    int cb;
                    int n;
                    string tag;
                    cb = (ca * 3 + 1) % 8;
                    en = 1'b0;
                    mode = m[0];
                    load_val = W'(l);
                    cmpa_val = W'(ca);
                    cmpb_val = W'(cb);
                    step();
                    check("R7", expv(m, l, ca, cb, 0));
                    en = 1'b1;
                    n = (m != 0) ? 4 * l + 3 : 2 * l + 3;
                    if (l == 0)      tag = "R8";
                    else if (m == 0) tag = "R1,R3,R4,R5";
                    else             tag = "R2,R3,R4,R5";
                    for (int k = 1; k <= n; k++) begin
                        step();
                        check(tag, expv(m, l, ca, cb, k));
                    end
                end
            end
        end

        // R6: period change mid-run in count-down mode takes effect after zero
        en = 1'b0;
        mode = 1'b0;
        load_val = 16'd5;
        cmpa_val = 16'd7;
        cmpb_val = 16'd7;
        step();
        en = 1'b1;
        step();
        step();
        check("R6", expv(0, 5, 7, 7, 2));
        load_val = 16'd2;
        begin
            int exp_cnt [7] = '{2, 1, 0, 2, 1, 0, 2};
            for (int i = 0; i < 7; i++) begin
                logic [W+6:0] e;
                int c;
                c = exp_cnt[i];
                e = {c[W-1:0], 1'b0, (c == 0), (c == 2 && i >= 3), 4'b0};
                step();
                check("R6", e);
            end
        end

        // R9: reset during an up/down run restarts the sequence
        en = 1'b0;
        mode = 1'b1;
        load_val = 16'd5;
        cmpa_val = 16'd2;
        cmpb_val = 16'd5;
        step();
        en = 1'b1;
        repeat (4) step();
        check("R2", expv(1, 5, 2, 5, 4));
        rst = 1'b1;
        step();
        check("R9", expv(1, 5, 2, 5, 0));
        rst = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            step();
            check("R9", expv(1, 5, 2, 5, k));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule